// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs whole I2C master transactions on top of a separate byte-level bus engine. One request carries a 7-bit target address, a direction, a register subaddress of zero to four bytes, and a data length. The block then walks the phases in order: address byte, subaddress bytes, repeated start when needed, data bytes, and stop. The engine handles all SCL/SDA bit timing. Clock stretching and arbitration are not part of this block.

The sequencer hands the engine one command at a time, using a valid/ready handshake. It then waits for that command's single response before it issues the next one. Write payload comes in on a byte stream. Read payload leaves on a byte output with a valid strobe. When a read has a subaddress, the block inserts a write phase and a repeated start on its own. It asks the engine to NAK only the final read byte. A slave NAK ends the transaction with a stop and an error flag, unless that NAK comes on the final write byte.

Top module: `i2c_seq_top`

## Requirements
- R1: While reset is held and on the first cycle after it: `cmd_valid`, `wr_ready`, `rd_valid`, `done`, `nak_err`, `req_busy` and `arg_err` are 0, and `xfer_count` is 0.
- R2: The first command of a transaction is kind START (`cmd_kind`=0), and its `cmd_byte` is `{req_addr, rw}`. The rw bit is 1 for a read with no subaddress and 0 in every other case.
- R3: Subaddress bytes go out as WRITE commands (`cmd_kind`=1), most significant byte first. The subaddress byte count is `req_sub_len` bytes taken from the low end of `req_sub`.
- R4: A read with a nonzero subaddress length issues a second START after the last subaddress byte, carrying `{req_addr, 1}`. A write never issues a second START.
- R5: A request is refused when `req_sub_len` > 4, or when 1 + `req_sub_len` + L > 14. L is `req_len` unless the request is a read with a subaddress, in which case L is 0. A refused request pulses `arg_err` for one cycle, one cycle after the request, and issues no command.
- R6: Write data bytes are taken from the `wr_data`/`wr_valid` stream in order. Each byte becomes one WRITE command, and `wr_ready` is high in the cycle that command is accepted.
- R7: A read sends one READ command (`cmd_kind`=2, `cmd_byte`=8'hFF) per byte. `cmd_nak` is 1 only on the final byte, and a 1-byte read NAKs its only byte. Each response's `rsp_data` appears on `rd_data` with `rd_valid` high for one cycle, one cycle after the response.
- R8: Every transaction that is not aborted ends with one STOP command (`cmd_kind`=3, `cmd_byte`=0). `done` pulses for one cycle, one cycle after the STOP response.
- R9: A slave NAK on the address, on a subaddress byte or on a write byte that is not the final one skips the remaining phases. The block goes straight to STOP and then reports `done` together with `nak_err`. A NAK on the final write byte completes normally, with `nak_err` at 0.
- R10: The `rsp_nak` input has no effect on READ responses.
- R11: A request made while a transaction is running pulses `req_busy` one cycle later and leaves the running transaction unchanged.
- R12: `xfer_count` equals the requested data length minus the data bytes still waiting for a response. A NAKed data byte counts as transferred.
- R13: `abort` returns the block to idle on the next clock: no further command is issued and no `done` pulse follows.
- R14: At most one command is outstanding: after a command is accepted, `cmd_valid` stays low until its response arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Transaction request strobe |
| req_addr | input | 7 | Target address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_sub_len | input | 3 | Subaddress length in bytes |
| req_sub | input | 32 | Subaddress value, right aligned |
| req_len | input | 8 | Data length in bytes |
| abort | input | 1 | Drop the current transaction |
| req_busy | output | 1 | Request refused because a transaction is running |
| arg_err | output | 1 | Request refused as invalid |
| done | output | 1 | Transaction finished |
| nak_err | output | 1 | Finished transaction ended on a slave NAK |
| xfer_count | output | 8 | Data bytes transferred so far |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Write payload byte consumed |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte strobe |
| cmd_valid | output | 1 | Command to the bus engine valid |
| cmd_ready | input | 1 | Bus engine accepts the command |
| cmd_kind | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_byte | output | 8 | Byte to shift out |
| cmd_nak | output | 1 | For READ: send NAK instead of ACK |
| rsp_valid | input | 1 | Bus engine finished the command |
| rsp_nak | input | 1 | Slave NAKed a START or WRITE |
| rsp_data | input | 8 | Byte received by a READ |

## Verification
There are three kinds of result, each due at a known point:
- The first command appears in the cycle after an accepted request, and each later command appears in the cycle after the previous response.
- `rd_valid`, `done` and `nak_err` rise in the cycle after the response that causes them.
- `req_busy` and `arg_err` rise in the cycle after the request, and `abort` takes effect on the next edge.

The bench drives inputs and samples outputs at the falling edge. A request is raised at one falling edge and its refusal pulse is checked at the next one. The engine model compares each command against the expected queue while `cmd_valid` is high. Completion flags and counts are read at the falling edge where `done` is seen, and the pulse is checked to be gone one edge later.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
// Shared types of the I2C transaction sequencer.
// Command codes are visible on the engine port and must stay fixed.
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_STOP  = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_SUB   = 3'd2,
        S_RADDR = 3'd3,
        S_DATA  = 3'd4,
        S_RX    = 3'd5,
        S_STOP  = 3'd6
    } seq_state_e;

endpackage

// File: rtl/i2c_seq_admit.sv
`timescale 1ns/1ps
// Request admission check.
// Works out whether a request needs a repeated start, and whether its first
// frame fits the engine's frame limit.
// Assumes: purely combinational; the result is used only while idle.
module i2c_seq_admit #(
    parameter int SUB_BYTES = 4,
    parameter int LEN_W     = 8,
    parameter int MAX_FRAME = 14,
    parameter int SL_W      = $clog2(SUB_BYTES + 1)
) (
    input  logic             read,
    input  logic [SL_W-1:0]  sub_len,
    input  logic [LEN_W-1:0] len,
    output logic             restart,
    output logic             ok
);
    localparam int FW = LEN_W + SL_W + 1;

    logic [FW-1:0] frame;

    // Frame length: address + subaddress + data, unless the data moves to a second frame.
    always_comb begin
        restart = read && (sub_len != '0);
        frame   = FW'(1) + FW'(sub_len) + (restart ? FW'(0) : FW'(len));
        ok      = (sub_len <= SL_W'(SUB_BYTES)) && (frame <= FW'(MAX_FRAME));
    end
endmodule

// File: rtl/i2c_seq_subsel.sv
`timescale 1ns/1ps
// Subaddress byte selector.
// Given the number of subaddress bytes still to send, returns the byte that
// goes out next, so that the most significant byte is sent first.
// Assumes: left == 0 or left > SUB_BYTES yields 0.
module i2c_seq_subsel #(
    parameter int SUB_BYTES = 4,
    parameter int SL_W      = $clog2(SUB_BYTES + 1)
) (
    input  logic [8*SUB_BYTES-1:0] sub,
    input  logic [SL_W-1:0]        left,
    output logic [7:0]             sel_byte
);
    logic [7:0] lanes [SUB_BYTES+1];

    assign lanes[0] = 8'h00;

    genvar g;
    generate
        for (g = 0; g < SUB_BYTES; g++) begin : g_lane
            assign lanes[g+1] = sub[8*g +: 8];
        end
    endgenerate

    // Pick lane `left`; out-of-range counts give zero.
    always_comb begin
        sel_byte = 8'h00;
        for (int i = 1; i <= SUB_BYTES; i++) begin
            if (left == SL_W'(i)) sel_byte = lanes[i];
        end
    end
endmodule

// File: rtl/i2c_seq_ctl.sv
`timescale 1ns/1ps
// Transaction controller of the I2C sequencer.
// Steps through the phases (address, subaddress, repeated start, data, stop),
// keeps one engine command outstanding, and reports completion.
// Assumes: the engine returns exactly one response per accepted command, and
// write payload bytes are presented by the stream in transaction order.
module i2c_seq_ctl
    import i2c_seq_pkg::*;
#(
    parameter int SUB_BYTES = 4,
    parameter int LEN_W     = 8,
    parameter int SL_W      = $clog2(SUB_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [6:0]             req_addr,
    input  logic                   req_read,
    input  logic [SL_W-1:0]        req_sub_len,
    input  logic [8*SUB_BYTES-1:0] req_sub,
    input  logic [LEN_W-1:0]       req_len,
    input  logic                   req_ok,
    input  logic                   req_restart,
    input  logic                   abort,
    output logic [8*SUB_BYTES-1:0] sub_q,
    output logic [SL_W-1:0]        sub_left,
    input  logic [7:0]             sub_byte,
    output logic                   req_busy,
    output logic                   arg_err,
    output logic                   done,
    output logic                   nak_err,
    output logic [LEN_W-1:0]       xfer_count,
    input  logic [7:0]             wr_data,
    input  logic                   wr_valid,
    output logic                   wr_ready,
    output logic [7:0]             rd_data,
    output logic                   rd_valid,
    output logic                   cmd_valid,
    input  logic                   cmd_ready,
    output logic [1:0]             cmd_kind,
    output logic [7:0]             cmd_byte,
    output logic                   cmd_nak,
    input  logic                   rsp_valid,
    input  logic                   rsp_nak,
    input  logic [7:0]             rsp_data
);
    seq_state_e       state;
    logic             pend;
    logic [6:0]       addr_q;
    logic             read_q;
    logic             restart_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] data_left;
    logic             err_q;
    logic             accept;
    cmd_kind_e        kind;

    // Phase that follows the header: the data phase of the direction, or stop when there is no data.
    function automatic seq_state_e body_state(input logic rd, input logic [LEN_W-1:0] left);
        if (left == '0) return S_STOP;
        return rd ? S_RX : S_DATA;
    endfunction

    // Command presented to the engine in each phase.
    always_comb begin
        kind     = CMD_STOP;
        cmd_byte = 8'h00;
        case (state)
            S_ADDR:  begin kind = CMD_START; cmd_byte = {addr_q, read_q & ~restart_q}; end
            S_RADDR: begin kind = CMD_START; cmd_byte = {addr_q, 1'b1}; end
            S_SUB:   begin kind = CMD_WRITE; cmd_byte = sub_byte; end
            S_DATA:  begin kind = CMD_WRITE; cmd_byte = wr_data; end
            S_RX:    begin kind = CMD_READ;  cmd_byte = 8'hFF; end
            default: begin kind = CMD_STOP;  cmd_byte = 8'h00; end
        endcase
        cmd_kind  = kind;
        cmd_valid = pend && (state != S_IDLE) && ((state != S_DATA) || wr_valid);
        cmd_nak   = (state == S_RX) && (data_left == LEN_W'(1));
        accept    = cmd_valid && cmd_ready;
        wr_ready  = accept && (state == S_DATA);
    end

    // Bytes counted as moved.
    assign xfer_count = len_q - data_left;

    // Phase sequencing, request admission and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            pend      <= 1'b0;
            addr_q    <= '0;
            read_q    <= 1'b0;
            restart_q <= 1'b0;
            sub_q     <= '0;
            sub_left  <= '0;
            len_q     <= '0;
            data_left <= '0;
            err_q     <= 1'b0;
            req_busy  <= 1'b0;
            arg_err   <= 1'b0;
            done      <= 1'b0;
            nak_err   <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            req_busy <= 1'b0;
            arg_err  <= 1'b0;
            done     <= 1'b0;
            nak_err  <= 1'b0;
            rd_valid <= 1'b0;
            if (abort) begin
                state <= S_IDLE;
                pend  <= 1'b0;
            end else if (state == S_IDLE) begin
                if (req_valid) begin
                    if (req_ok) begin
                        addr_q    <= req_addr;
                        read_q    <= req_read;
                        restart_q <= req_restart;
                        sub_q     <= req_sub;
                        sub_left  <= req_sub_len;
                        len_q     <= req_len;
                        data_left <= req_len;
                        err_q     <= 1'b0;
                        state     <= S_ADDR;
                        pend      <= 1'b1;
                    end else begin
                        arg_err <= 1'b1;
                    end
                end
            end else begin
                if (req_valid) req_busy <= 1'b1;
                if (accept) pend <= 1'b0;
                if (!pend && rsp_valid) begin
                    pend <= 1'b1;
                    case (state)
                        S_ADDR: begin
                            if (rsp_nak) begin
                                err_q <= 1'b1;
                                state <= S_STOP;
                            end else if (sub_left != '0) begin
                                state <= S_SUB;
                            end else begin
                                state <= body_state(read_q, data_left);
                            end
                        end
                        S_SUB: begin
                            if (rsp_nak) begin
                                err_q <= 1'b1;
                                state <= S_STOP;
                            end else begin
                                sub_left <= sub_left - 1'b1;
                                if (sub_left == SL_W'(1))
                                    state <= restart_q ? S_RADDR : body_state(read_q, data_left);
                            end
                        end
                        S_RADDR: begin
                            if (rsp_nak) begin
                                err_q <= 1'b1;
                                state <= S_STOP;
                            end else begin
                                state <= body_state(1'b1, data_left);
                            end
                        end
                        S_DATA: begin
                            data_left <= data_left - 1'b1;
                            if (rsp_nak && (data_left != LEN_W'(1))) begin
                                err_q <= 1'b1;
                                state <= S_STOP;
                            end else if (data_left == LEN_W'(1)) begin
                                state <= S_STOP;
                            end
                        end
                        S_RX: begin
                            rd_valid  <= 1'b1;
                            rd_data   <= rsp_data;
                            data_left <= data_left - 1'b1;
                            if (data_left == LEN_W'(1)) state <= S_STOP;
                        end
                        S_STOP: begin
                            state   <= S_IDLE;
                            pend    <= 1'b0;
                            done    <= 1'b1;
                            nak_err <= err_q;
                        end
                        default: begin
                            state <= S_IDLE;
                            pend  <= 1'b0;
                        end
                    endcase
                end
            end
        end
    end

    // R14
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    // R13
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == S_IDLE) && !done && !cmd_valid);

    // R8
    done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rsp_valid) && $past(state == S_STOP));

    // R7
    rd_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rsp_valid) && $past(state == S_RX));

    // R12
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_count <= len_q);

    // R5
    arg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arg_err |-> (state == S_IDLE) && !cmd_valid);

    // R11
    busy_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_busy |-> $past(state != S_IDLE));

    // R9
    nak_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nak_err |-> done);

endmodule

// File: rtl/i2c_seq_top.sv
`timescale 1ns/1ps
// I2C master transaction sequencer, top level.
// Connects request admission, subaddress byte selection and the transaction
// controller. Bit timing lives in an external byte engine on the cmd/rsp port.
// Assumes: 7-bit addressing; one response per accepted engine command.
module i2c_seq_top #(
    parameter int SUB_BYTES = 4,
    parameter int LEN_W     = 8,
    parameter int MAX_FRAME = 14
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [6:0]                        req_addr,
    input  logic                              req_read,
    input  logic [$clog2(SUB_BYTES+1)-1:0]    req_sub_len,
    input  logic [8*SUB_BYTES-1:0]            req_sub,
    input  logic [LEN_W-1:0]                  req_len,
    input  logic                              abort,
    output logic                              req_busy,
    output logic                              arg_err,
    output logic                              done,
    output logic                              nak_err,
    output logic [LEN_W-1:0]                  xfer_count,
    input  logic [7:0]                        wr_data,
    input  logic                              wr_valid,
    output logic                              wr_ready,
    output logic [7:0]                        rd_data,
    output logic                              rd_valid,
    output logic                              cmd_valid,
    input  logic                              cmd_ready,
    output logic [1:0]                        cmd_kind,
    output logic [7:0]                        cmd_byte,
    output logic                              cmd_nak,
    input  logic                              rsp_valid,
    input  logic                              rsp_nak,
    input  logic [7:0]                        rsp_data
);
    localparam int SL_W = $clog2(SUB_BYTES + 1);

    logic                   req_ok;
    logic                   req_restart;
    logic [8*SUB_BYTES-1:0] sub_q;
    logic [SL_W-1:0]        sub_left;
    logic [7:0]             sub_byte;

    i2c_seq_admit #(
        .SUB_BYTES(SUB_BYTES), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .SL_W(SL_W)
    ) u_admit (
        .read(req_read), .sub_len(req_sub_len), .len(req_len),
        .restart(req_restart), .ok(req_ok)
    );

    i2c_seq_subsel #(
        .SUB_BYTES(SUB_BYTES), .SL_W(SL_W)
    ) u_subsel (
        .sub(sub_q), .left(sub_left), .sel_byte(sub_byte)
    );

    i2c_seq_ctl #(
        .SUB_BYTES(SUB_BYTES), .LEN_W(LEN_W), .SL_W(SL_W)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_read(req_read),
        .req_sub_len(req_sub_len), .req_sub(req_sub), .req_len(req_len),
        .req_ok(req_ok), .req_restart(req_restart), .abort(abort),
        .sub_q(sub_q), .sub_left(sub_left), .sub_byte(sub_byte),
        .req_busy(req_busy), .arg_err(arg_err), .done(done), .nak_err(nak_err),
        .xfer_count(xfer_count),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_byte(cmd_byte), .cmd_nak(cmd_nak),
        .rsp_valid(rsp_valid), .rsp_nak(rsp_nak), .rsp_data(rsp_data)
    );
endmodule

// File: tb/i2c_seq_top_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task queues the expected engine commands and
// read bytes; the engine model and read monitor pop and compare them.
module i2c_seq_top_test;

    typedef struct {
        logic [1:0] kind;
        logic [7:0] byt;
        logic       nak;
        bit         is_data;
        string      rq;
    } exp_t;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic [6:0]  req_addr;
    logic        req_read;
    logic [2:0]  req_sub_len;
    logic [31:0] req_sub;
    logic [7:0]  req_len;
    logic        abort;
    logic        req_busy, arg_err, done, nak_err;
    logic [7:0]  xfer_count;
    logic [7:0]  wr_data;
    logic        wr_valid, wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        cmd_valid, cmd_ready;
    logic [1:0]  cmd_kind;
    logic [7:0]  cmd_byte;
    logic        cmd_nak;
    logic        rsp_valid, rsp_nak;
    logic [7:0]  rsp_data;

    exp_t       exp_cmd[$];
    logic [7:0] exp_rd[$];
    logic [7:0] wsrc[$];
    int         nak_at;
    bit         rd_nak_all;
    int         cmd_idx;
    int         checks;
    int         errors;
    bit         finished;
    exp_t       eng_e;
    bit         eng_took;
    logic [1:0] eng_kind;

    i2c_seq_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_read(req_read), .req_sub_len(req_sub_len), .req_sub(req_sub),
        .req_len(req_len), .abort(abort), .req_busy(req_busy), .arg_err(arg_err),
        .done(done), .nak_err(nak_err), .xfer_count(xfer_count),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte),
        .cmd_nak(cmd_nak), .rsp_valid(rsp_valid), .rsp_nak(rsp_nak),
        .rsp_data(rsp_data)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    task automatic check_eq(string rq, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic refresh_src();
        wr_valid = (wsrc.size() > 0);
        wr_data  = (wsrc.size() > 0) ? wsrc[0] : 8'h00;
    endtask

    // Engine model and command monitor.
    initial begin
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_nak   = 1'b0;
        rsp_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                eng_kind = cmd_kind;
                if (exp_cmd.size() == 0) begin
                    check_eq("R14", "unexpected command kind", int'(cmd_kind), 99);
                end else begin
                    eng_e = exp_cmd.pop_front();
                    check_eq(eng_e.rq, "cmd_kind", int'(cmd_kind), int'(eng_e.kind));
                    check_eq(eng_e.rq, "cmd_byte", int'(cmd_byte), int'(eng_e.byt));
                    check_eq(eng_e.rq, "cmd_nak", int'(cmd_nak), int'(eng_e.nak));
                end
                cmd_ready = 1'b1;
                #1 eng_took = wr_ready;
                @(negedge clk);
                cmd_ready = 1'b0;
                if (eng_took && wsrc.size() > 0) begin
                    void'(wsrc.pop_front());
                    refresh_src();
                end
                @(negedge clk);
                rsp_valid = 1'b1;
                rsp_nak   = (cmd_idx == nak_at) || ((eng_kind == 2'd2) && rd_nak_all);
                rsp_data  = 8'(8'hA0 + cmd_idx);
                cmd_idx++;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_nak   = 1'b0;
            end
        end
    end

    // Read payload monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) begin
                if (exp_rd.size() == 0)
                    check_eq("R7", "unexpected rd_valid", int'(rd_data), 999);
                else
                    check_eq("R7", "rd_data", int'(rd_data), int'(exp_rd.pop_front()));
            end
        end
    end

    task automatic pulse_req(input logic [6:0] a, input bit rd, input int slen,
                             input logic [31:0] sub, input int len);
        @(negedge clk);
        req_addr    = a;
        req_read    = rd;
        req_sub_len = 3'(slen);
        req_sub     = sub;
        req_len     = 8'(len);
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    // Builds the expected command list from the requirements, then issues the request.
    task automatic start_xfer(input logic [6:0] a, input bit rd, input int slen,
                              input logic [31:0] sub, input int len, input int nakpos,
                              input bit rdnak, output bit exp_err, output int exp_cnt);
        exp_t lst[$];
        exp_t e;
        bit   restart;
        bit   exempt;
        int   ndata;
        restart = rd && (slen != 0);
        e.nak = 1'b0; e.is_data = 1'b0;
        e.kind = 2'd0; e.byt = {a, rd & !restart}; e.rq = "R2";
        lst.push_back(e);
        for (int i = slen - 1; i >= 0; i--) begin
            e.kind = 2'd1; e.byt = sub[8*i +: 8]; e.rq = "R3";
            lst.push_back(e);
        end
        if (restart) begin
            e.kind = 2'd0; e.byt = {a, 1'b1}; e.rq = "R4";
            lst.push_back(e);
        end
        wsrc.delete();
        for (int i = 0; i < len; i++) begin
            if (!rd) begin
                e.kind = 2'd1; e.byt = 8'(8'h5A ^ (i * 3 + 1)); e.nak = 1'b0;
                e.is_data = 1'b1; e.rq = "R6";
                wsrc.push_back(e.byt);
            end else begin
                e.kind = 2'd2; e.byt = 8'hFF; e.nak = (i == len - 1);
                e.is_data = 1'b1; e.rq = "R7";
            end
            lst.push_back(e);
        end
        exp_err = 1'b0;
        exp_cnt = len;
        if (nakpos >= 0 && nakpos < lst.size()) begin
            exempt = lst[nakpos].is_data && (nakpos == lst.size() - 1);
            if (!exempt) begin
                exp_err = 1'b1;
                ndata = 0;
                for (int i = 0; i <= nakpos; i++) if (lst[i].is_data) ndata++;
                exp_cnt = ndata;
                lst = lst[0:nakpos];
            end
        end
        e.kind = 2'd3; e.byt = 8'h00; e.nak = 1'b0; e.is_data = 1'b0; e.rq = "R8";
        lst.push_back(e);
        exp_rd.delete();
        for (int i = 0; i < lst.size(); i++)
            if (lst[i].kind == 2'd2) exp_rd.push_back(8'(8'hA0 + i));
        exp_cmd    = lst;
        nak_at     = nakpos;
        rd_nak_all = rdnak;
        cmd_idx    = 0;
        refresh_src();
        pulse_req(a, rd, slen, sub, len);
    endtask

    task automatic finish_xfer(input bit exp_err, input int exp_cnt, input string tag);
        int waited;
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check_eq("R8", {tag, " done seen"}, int'(done), 1);
        check_eq("R9", {tag, " nak_err"}, int'(nak_err), int'(exp_err));
        check_eq("R12", {tag, " xfer_count"}, int'(xfer_count), exp_cnt);
        check_eq("R8", {tag, " commands left"}, exp_cmd.size(), 0);
        check_eq("R7", {tag, " read bytes left"}, exp_rd.size(), 0);
        @(negedge clk);
        check_eq("R8", {tag, " done one cycle"}, int'(done), 0);
        wsrc.delete();
        refresh_src();
        repeat (3) @(negedge clk);
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        bit ee;
        int ec;
        int dsnap;
        checks = 0; errors = 0; finished = 1'b0;
        nak_at = -1; rd_nak_all = 1'b0; cmd_idx = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_read = 1'b0;
        req_sub_len = '0; req_sub = '0; req_len = '0; abort = 1'b0;
        refresh_src();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "cmd_valid", int'(cmd_valid), 0);
        check_eq("R1", "wr_ready", int'(wr_ready), 0);
        check_eq("R1", "rd_valid", int'(rd_valid), 0);
        check_eq("R1", "done", int'(done), 0);
        check_eq("R1", "nak_err", int'(nak_err), 0);
        check_eq("R1", "req_busy", int'(req_busy), 0);
        check_eq("R1", "arg_err", int'(arg_err), 0);
        check_eq("R1", "xfer_count", int'(xfer_count), 0);

        // R2 R6 plain write
        start_xfer(7'h2C, 1'b0, 0, 32'h0, 3, -1, 1'b0, ee, ec);
        finish_xfer(ee, ec, "write3");
        // R3 write with 2-byte subaddress
        start_xfer(7'h11, 1'b0, 2, 32'h0000BEEF, 2, -1, 1'b0, ee, ec);
        finish_xfer(ee, ec, "write_sub2");
        // R7 read, no subaddress
        start_xfer(7'h50, 1'b1, 0, 32'h0, 3, -1, 1'b0, ee, ec);
        finish_xfer(ee, ec, "read3");
        // R4 read with 3-byte subaddress, repeated start
        start_xfer(7'h68, 1'b1, 3, 32'h00123456, 2, -1, 1'b0, ee, ec);
        finish_xfer(ee, ec, "read_restart");
        // R7 single-byte read NAKed at once
        start_xfer(7'h1E, 1'b1, 1, 32'h000000C3, 1, -1, 1'b0, ee, ec);
        finish_xfer(ee, ec, "read1");
        // R5 boundary: frame of exactly 14 accepted
        start_xfer(7'h33, 1'b0, 1, 32'h00000077, 12, -1, 1'b0, ee, ec);
        finish_xfer(ee, ec, "frame14");
        // R5 read with 4-byte subaddress and long data: data leaves the first frame
        start_xfer(7'h7F, 1'b1, 4, 32'hDEADC0DE, 40, -1, 1'b0, ee, ec);
        finish_xfer(ee, ec, "read_sub4_len40");

        // R5 frame of 15 refused
        exp_cmd.delete(); exp_rd.delete();
        pulse_req(7'h22, 1'b0, 2, 32'h0101, 12);
        check_eq("R5", "arg_err frame15", int'(arg_err), 1);
        dsnap = 0;
        repeat (10) begin @(negedge clk); if (done) dsnap++; end
        check_eq("R5", "no done after refusal", dsnap, 0);
        // R5 subaddress length 5 refused
        pulse_req(7'h22, 1'b0, 5, 32'h0101, 1);
        check_eq("R5", "arg_err sub5", int'(arg_err), 1);
        repeat (6) @(negedge clk);
        // R5 write with no subaddress and 14 data bytes refused (frame 15)
        pulse_req(7'h22, 1'b0, 0, 32'h0, 14);
        check_eq("R5", "arg_err len14", int'(arg_err), 1);
        repeat (6) @(negedge clk);

        // R9 NAK on address
        start_xfer(7'h40, 1'b0, 1, 32'h5, 3, 0, 1'b0, ee, ec);
        finish_xfer(ee, ec, "nak_addr");
        // R9 NAK on a subaddress byte of a read
        start_xfer(7'h41, 1'b1, 2, 32'hA1B2, 3, 1, 1'b0, ee, ec);
        finish_xfer(ee, ec, "nak_sub");
        // R9 R12 NAK on the second of four write bytes
        start_xfer(7'h42, 1'b0, 0, 32'h0, 4, 2, 1'b0, ee, ec);
        finish_xfer(ee, ec, "nak_mid_write");
        // R9 NAK on the final write byte is not an error
        start_xfer(7'h43, 1'b0, 1, 32'h9, 3, 4, 1'b0, ee, ec);
        check_eq("R9", "final nak is exempt", int'(ee), 0);
        finish_xfer(ee, ec, "nak_last_write");
        // R10 rsp_nak on read responses ignored
        start_xfer(7'h44, 1'b1, 0, 32'h0, 3, -1, 1'b1, ee, ec);
        finish_xfer(ee, ec, "read_nak_ignored");

        // R11 request while busy
        start_xfer(7'h45, 1'b0, 1, 32'h3C, 3, -1, 1'b0, ee, ec);
        repeat (4) @(negedge clk);
        pulse_req(7'h01, 1'b1, 0, 32'h0, 1);
        check_eq("R11", "req_busy", int'(req_busy), 1);
        check_eq("R11", "arg_err while busy", int'(arg_err), 0);
        finish_xfer(ee, ec, "busy");

        // R13 abort mid transaction
        start_xfer(7'h46, 1'b0, 0, 32'h0, 6, -1, 1'b0, ee, ec);
        repeat (14) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check_eq("R13", "cmd_valid after abort", int'(cmd_valid), 0);
        exp_cmd.delete();
        dsnap = 0;
        repeat (12) begin @(negedge clk); if (done) dsnap++; end
        check_eq("R13", "no done after abort", dsnap, 0);
        exp_cmd.delete(); exp_rd.delete(); wsrc.delete(); refresh_src();
        // R13 idle again: a new request is served
        start_xfer(7'h47, 1'b1, 0, 32'h0, 2, -1, 1'b0, ee, ec);
        finish_xfer(ee, ec, "after_abort");

        finished = 1'b1;
        report();
        $finish;
    end

endmodule